// File: doc/BRIEF.md
# Password-Gated Clock-Control Register Bank

This block is the register file that sits in front of a clock controller. It answers 32-bit accesses into an 8 KB window. A small set of words is backed by storage: one pair of words for each PLL (a manager word and an analog word), one word for each PLL output channel, and one pair of words for each clock mux (control, then divide). One further word reports whether each PLL is locked. That word is not stored. It is assembled at read time from the PLLs' power-down and analog-reset bits.

A write is taken only when its top byte carries the magic key. The key byte is removed before the value is kept. Any other write disappears without trace. Partial-width and misaligned accesses are refused. After every accepted write, a one-cycle update pulse tells the clock datapath which word changed and which PLL, channel or mux owns it. The datapath can then recompute only that unit.

Top module: `cm_regbank`

## Requirements
- R1: After reset, no output pulse is present. The stored words read back their defaults: PLL manager words 0x00000100, PLL analog words 0x00010000, channel words 0x00000100, mux control words 0x00000000 and mux divide words 0x00001000. With these defaults the lock word reads 0.
- R2: A full, aligned write whose bits 31:24 equal 0x5A to a stored word keeps bits 23:0 only. A later read returns those bits with bits 31:24 zero.
- R3: A write whose bits 31:24 differ from 0x5A leaves every stored word unchanged and raises no update pulse.
- R4: An access with byte enables other than 4'hF, or with address bits 1:0 non-zero, is refused. A refused write changes nothing and raises no pulse. A refused read returns 0.
- R5: The lock word is word 2 (byte 0x008). Its bit 8+p is 1 exactly when, for PLL p, bit 8 (analog reset) of that PLL's manager word is 0 and bit 16 (power-down) of its analog word is 0. All other bits read 0.
- R6: An accepted write to a stored word raises upd_valid for exactly the next cycle. With it, upd_idx carries the word index (byte address / 4), and upd_kind and upd_unit name the owner. The owners are: words 4..7 are PLL manager words, kind 0, unit p; words 16..19 are PLL analog words, kind 1, unit p; words 32..39 are channel words, kind 2, unit c.
- R7: Words 64..71 are mux pairs. The even word is control and the odd word is divide. A write to either word of mux m reports kind 3 and unit m.
- R8: Writes to the lock word or to any unmapped word have no effect and raise no pulse. Unmapped words read 0.
- R9: Every read request yields rd_valid with rd_data exactly one cycle later.
- R10: Without an accepted write, upd_valid stays low, and rd_valid is low when there is no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Byte address within the window |
| bus_strb | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data, key in bits 31:24 |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| upd_valid | output | 1 | One-cycle update pulse |
| upd_idx | output | 11 | Word index of the accepted write |
| upd_kind | output | 2 | Owner class: 0 PLL manager, 1 PLL analog, 2 channel, 3 mux |
| upd_unit | output | 4 | PLL, channel or mux number |

## Verification
The bench first walks every stored word with keyed writes and read-backs. This separates correct slot mapping and key stripping from aliasing between neighbouring words. It then retries the same words with a wrong key, partial byte enables and an offset address. Values that stick after these attempts expose a gate that is missing or too loose. The lock word is driven through each combination of analog-reset and power-down for several PLLs, which separates an AND of both conditions from an OR and checks that each flag lands on its own bit. Mux control and divide writes are paired to show that both report the same mux. Writes to unmapped and read-only words confirm that they stay silent.

// File: rtl/cm_regbank_pkg.sv
package cm_regbank_pkg;
    localparam int         KEY_W   = 8;
    localparam logic [7:0] KEY_VAL = 8'h5A;
    localparam int         BUS_W   = 32;
    localparam int         DATA_W  = BUS_W - KEY_W;

    localparam logic [1:0] KIND_PLL_MGR = 2'd0;
    localparam logic [1:0] KIND_PLL_ANA = 2'd1;
    localparam logic [1:0] KIND_CHAN    = 2'd2;
    localparam logic [1:0] KIND_MUX     = 2'd3;
endpackage

// File: rtl/cm_word_decode.sv
module cm_word_decode #(
    parameter int IDX_W        = 11,
    parameter int UNIT_W       = 4,
    parameter int SLOT_W       = 5,
    parameter int NUM_PLL      = 4,
    parameter int NUM_CHAN     = 8,
    parameter int NUM_MUX      = 4,
    parameter int LOCK_IDX     = 2,
    parameter int PLL_MGR_BASE = 4,
    parameter int PLL_ANA_BASE = 16,
    parameter int CHAN_BASE    = 32,
    parameter int MUX_BASE     = 64
) (
    input  logic [IDX_W-1:0]  word_idx,
    output logic              is_lock,
    output logic              hit,
    output logic [1:0]        kind,
    output logic [UNIT_W-1:0] unit,
    output logic [SLOT_W-1:0] slot
);
    import cm_regbank_pkg::*;

    localparam int SLOT_ANA  = NUM_PLL;
    localparam int SLOT_CHAN = 2 * NUM_PLL;
    localparam int SLOT_MUX  = 2 * NUM_PLL + NUM_CHAN;

    logic [IDX_W-1:0] off_mgr, off_ana, off_chan, off_mux;

    always_comb begin
        off_mgr  = word_idx - IDX_W'(PLL_MGR_BASE);
        off_ana  = word_idx - IDX_W'(PLL_ANA_BASE);
        off_chan = word_idx - IDX_W'(CHAN_BASE);
        off_mux  = word_idx - IDX_W'(MUX_BASE);
        is_lock  = (word_idx == IDX_W'(LOCK_IDX));
        hit      = 1'b0;
        kind     = KIND_PLL_MGR;
        unit     = '0;
        slot     = '0;
        if (off_mgr < IDX_W'(NUM_PLL)) begin
            hit  = 1'b1;
            kind = KIND_PLL_MGR;
            unit = UNIT_W'(off_mgr);
            slot = SLOT_W'(off_mgr);
        end else if (off_ana < IDX_W'(NUM_PLL)) begin
            hit  = 1'b1;
            kind = KIND_PLL_ANA;
            unit = UNIT_W'(off_ana);
            slot = SLOT_W'(SLOT_ANA) + SLOT_W'(off_ana);
        end else if (off_chan < IDX_W'(NUM_CHAN)) begin
            hit  = 1'b1;
            kind = KIND_CHAN;
            unit = UNIT_W'(off_chan);
            slot = SLOT_W'(SLOT_CHAN) + SLOT_W'(off_chan);
        end else if (off_mux < IDX_W'(2 * NUM_MUX)) begin
            hit  = 1'b1;
            kind = KIND_MUX;
            unit = UNIT_W'(off_mux >> 1);
            slot = SLOT_W'(SLOT_MUX) + SLOT_W'(off_mux);
        end
    end
endmodule

// File: rtl/cm_lock_gather.sv
module cm_lock_gather #(
    parameter int NUM_PLL    = 4,
    parameter int LOCK_SHIFT = 8
) (
    input  logic [NUM_PLL-1:0] pll_arst,
    input  logic [NUM_PLL-1:0] pll_pwrdn,
    output logic [31:0]        lock_word
);
    logic [NUM_PLL-1:0] locked;

    for (genvar p = 0; p < NUM_PLL; p++) begin : g_pll
        assign locked[p] = ~pll_arst[p] & ~pll_pwrdn[p];
    end

    assign lock_word = 32'(locked) << LOCK_SHIFT;
endmodule

// File: rtl/cm_regbank.sv
module cm_regbank #(
    parameter int          WINDOW_BYTES = 8192,
    parameter int          NUM_PLL      = 4,
    parameter int          NUM_CHAN     = 8,
    parameter int          NUM_MUX      = 4,
    parameter int          LOCK_IDX     = 2,
    parameter int          PLL_MGR_BASE = 4,
    parameter int          PLL_ANA_BASE = 16,
    parameter int          CHAN_BASE    = 32,
    parameter int          MUX_BASE     = 64,
    parameter int          ARST_BIT     = 8,
    parameter int          PWRDN_BIT    = 16,
    parameter int          LOCK_SHIFT   = 8,
    parameter logic [31:0] MGR_DEFAULT  = 32'h0000_0100,
    parameter logic [31:0] ANA_DEFAULT  = 32'h0001_0000,
    parameter logic [31:0] CHAN_DEFAULT = 32'h0000_0100,
    parameter logic [31:0] CTL_DEFAULT  = 32'h0000_0000,
    parameter logic [31:0] DIV_DEFAULT  = 32'h0000_1000,
    localparam int ADDR_W   = $clog2(WINDOW_BYTES),
    localparam int IDX_W    = ADDR_W - 2,
    localparam int MAX_UNIT = (NUM_CHAN > NUM_PLL)
                              ? ((NUM_CHAN > NUM_MUX) ? NUM_CHAN : NUM_MUX)
                              : ((NUM_PLL > NUM_MUX) ? NUM_PLL : NUM_MUX),
    localparam int UNIT_W   = (MAX_UNIT > 1) ? $clog2(MAX_UNIT) + 1 : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_strb,
    input  logic [31:0]       bus_wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              upd_valid,
    output logic [IDX_W-1:0]  upd_idx,
    output logic [1:0]        upd_kind,
    output logic [UNIT_W-1:0] upd_unit
);
    import cm_regbank_pkg::*;

    localparam int NUM_SLOTS = 2 * NUM_PLL + NUM_CHAN + 2 * NUM_MUX;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int SLOT_CHAN = 2 * NUM_PLL;
    localparam int SLOT_MUX  = 2 * NUM_PLL + NUM_CHAN;

    typedef struct packed {
        logic [NUM_SLOTS-1:0][DATA_W-1:0] regs;
        logic                             rd_valid;
        logic [BUS_W-1:0]                 rd_data;
        logic                             upd_valid;
        logic [IDX_W-1:0]                 upd_idx;
        logic [1:0]                       upd_kind;
        logic [UNIT_W-1:0]                upd_unit;
    } st_t;

    function automatic st_t reset_state();
        st_t s;
        s = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (i < NUM_PLL)
                s.regs[i] = DATA_W'(MGR_DEFAULT);
            else if (i < SLOT_CHAN)
                s.regs[i] = DATA_W'(ANA_DEFAULT);
            else if (i < SLOT_MUX)
                s.regs[i] = DATA_W'(CHAN_DEFAULT);
            else if (((i - SLOT_MUX) % 2) == 0)
                s.regs[i] = DATA_W'(CTL_DEFAULT);
            else
                s.regs[i] = DATA_W'(DIV_DEFAULT);
        end
        return s;
    endfunction

    st_t st_d, st_q;

    logic [IDX_W-1:0]   word_idx;
    logic               dec_lock, dec_hit;
    logic [1:0]         dec_kind;
    logic [UNIT_W-1:0]  dec_unit;
    logic [SLOT_W-1:0]  dec_slot;
    logic [NUM_PLL-1:0] pll_arst, pll_pwrdn;
    logic [31:0]        lock_word;
    logic               full_word, key_ok;

    assign word_idx = bus_addr[ADDR_W-1:2];

    cm_word_decode #(
        .IDX_W(IDX_W), .UNIT_W(UNIT_W), .SLOT_W(SLOT_W),
        .NUM_PLL(NUM_PLL), .NUM_CHAN(NUM_CHAN), .NUM_MUX(NUM_MUX),
        .LOCK_IDX(LOCK_IDX), .PLL_MGR_BASE(PLL_MGR_BASE),
        .PLL_ANA_BASE(PLL_ANA_BASE), .CHAN_BASE(CHAN_BASE), .MUX_BASE(MUX_BASE)
    ) u_dec (
        .word_idx(word_idx),
        .is_lock (dec_lock),
        .hit     (dec_hit),
        .kind    (dec_kind),
        .unit    (dec_unit),
        .slot    (dec_slot)
    );

    for (genvar p = 0; p < NUM_PLL; p++) begin : g_lock_src
        assign pll_arst[p]  = st_q.regs[p][ARST_BIT];
        assign pll_pwrdn[p] = st_q.regs[NUM_PLL + p][PWRDN_BIT];
    end

    cm_lock_gather #(
        .NUM_PLL(NUM_PLL), .LOCK_SHIFT(LOCK_SHIFT)
    ) u_lock (
        .pll_arst (pll_arst),
        .pll_pwrdn(pll_pwrdn),
        .lock_word(lock_word)
    );

    always_comb begin
        full_word = (bus_strb == 4'hF) && (bus_addr[1:0] == 2'b00);
        key_ok    = (bus_wdata[BUS_W-1:DATA_W] == KEY_VAL);
        st_d           = st_q;
        st_d.rd_valid  = 1'b0;
        st_d.rd_data   = '0;
        st_d.upd_valid = 1'b0;
        if (bus_valid && !bus_write) begin
            st_d.rd_valid = 1'b1;
            if (full_word && dec_lock)
                st_d.rd_data = lock_word;
            else if (full_word && dec_hit)
                st_d.rd_data = {{KEY_W{1'b0}}, st_q.regs[dec_slot]};
        end else if (bus_valid && full_word && key_ok && dec_hit) begin
            st_d.regs[dec_slot] = bus_wdata[DATA_W-1:0];
            st_d.upd_valid      = 1'b1;
            st_d.upd_idx        = word_idx;
            st_d.upd_kind       = dec_kind;
            st_d.upd_unit       = dec_unit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end

    assign rd_valid  = st_q.rd_valid;
    assign rd_data   = st_q.rd_data;
    assign upd_valid = st_q.upd_valid;
    assign upd_idx   = st_q.upd_idx;
    assign upd_kind  = st_q.upd_kind;
    assign upd_unit  = st_q.upd_unit;
endmodule

// File: rtl/cm_regbank_chk.sv
module cm_regbank_chk #(
    parameter int ADDR_W     = 13,
    parameter int IDX_W      = 11,
    parameter int UNIT_W     = 4,
    parameter int NUM_PLL    = 4,
    parameter int LOCK_IDX   = 2,
    parameter int LOCK_SHIFT = 8,
    parameter int MUX_BASE   = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [3:0]        bus_strb,
    input logic [31:0]       bus_wdata,
    input logic              rd_valid,
    input logic [31:0]       rd_data,
    input logic              upd_valid,
    input logic [IDX_W-1:0]  upd_idx,
    input logic [1:0]        upd_kind,
    input logic [UNIT_W-1:0] upd_unit
);
    import cm_regbank_pkg::*;

    localparam logic [31:0] LOCK_MASK = ((32'd1 << NUM_PLL) - 32'd1) << LOCK_SHIFT;

    logic rd_req, wr_req, refused, lock_addr;
    assign rd_req    = bus_valid && !bus_write;
    assign wr_req    = bus_valid && bus_write;
    assign refused   = (bus_strb != 4'hF) || (bus_addr[1:0] != 2'b00);
    assign lock_addr = (bus_addr[ADDR_W-1:2] == IDX_W'(LOCK_IDX));

    a_r2_key_byte_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> rd_data[31:24] == 8'h00);
    a_r3_bad_key_silent: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && bus_wdata[31:24] != KEY_VAL |=> !upd_valid);
    a_r4_refused_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && refused |=> !upd_valid);
    a_r4_refused_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && refused |=> rd_data == 32'h0);
    a_r5_lock_spare_bits: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !refused && lock_addr |=> (rd_data & ~LOCK_MASK) == 32'h0);
    a_r6_upd_index: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> upd_idx == $past(bus_addr[ADDR_W-1:2]));
    a_r7_mux_pair_unit: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid && upd_kind == KIND_MUX |->
            upd_unit == UNIT_W'((upd_idx - IDX_W'(MUX_BASE)) >> 1));
    a_r8_lock_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && lock_addr |=> !upd_valid);
    a_r9_read_answer: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);
    a_r10_no_stray_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req));
    a_r10_no_stray_update: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> $past(wr_req));
endmodule

bind cm_regbank cm_regbank_chk #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .UNIT_W(UNIT_W), .NUM_PLL(NUM_PLL),
    .LOCK_IDX(LOCK_IDX), .LOCK_SHIFT(LOCK_SHIFT), .MUX_BASE(MUX_BASE)
) u_chk (.*);

// File: tb/cm_regbank_tb.sv
`timescale 1ns/1ps
module cm_regbank_tb;
    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [3:0]  bus_strb = '0;
    logic [31:0] bus_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        upd_valid;
    logic [10:0] upd_idx;
    logic [1:0]  upd_kind;
    logic [3:0]  upd_unit;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [31:0] mem [int];

    always #(HALF) clk = ~clk;

    cm_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_strb(bus_strb), .bus_wdata(bus_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .upd_valid(upd_valid),
        .upd_idx(upd_idx), .upd_kind(upd_kind), .upd_unit(upd_unit)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit owner(int w, output int kind, output int unit);
        kind = 0; unit = 0;
        if (w >= 4 && w < 8)        begin kind = 0; unit = w - 4;         return 1; end
        else if (w >= 16 && w < 20) begin kind = 1; unit = w - 16;        return 1; end
        else if (w >= 32 && w < 40) begin kind = 2; unit = w - 32;        return 1; end
        else if (w >= 64 && w < 72) begin kind = 3; unit = (w - 64) / 2;  return 1; end
        return 0;
    endfunction

    function automatic logic [31:0] model_read(int w);
        int k, u;
        logic [31:0] r;
        if (w == 2) begin
            r = 0;
            for (int p = 0; p < 4; p++)
                if (!mem[4+p][8] && !mem[16+p][16]) r[8+p] = 1'b1;
            return r;
        end
        if (owner(w, k, u)) return mem[w];
        return 32'h0;
    endfunction

    task automatic model_reset();
        mem.delete();
        for (int p = 0; p < 4; p++) begin mem[4+p] = 32'h100; mem[16+p] = 32'h10000; end
        for (int c = 0; c < 8; c++) mem[32+c] = 32'h100;
        for (int m = 0; m < 4; m++) begin mem[64+2*m] = 32'h0; mem[65+2*m] = 32'h1000; end
    endtask

    // Called at a negedge; drives one access, compares at the following negedge.
    task automatic access(bit wr, int addr, logic [3:0] strb, logic [31:0] data, string req);
        int w, k, u;
        bit full, acc, exp_rv, exp_uv;
        logic [31:0] exp_rd;
        w = addr >> 2;
        full = (strb == 4'hF) && (addr % 4 == 0);
        exp_rv = !wr;
        exp_rd = (!wr && full) ? model_read(w) : 32'h0;
        acc = wr && full && data[31:24] == 8'h5A && owner(w, k, u);
        exp_uv = acc;
        bus_valid = 1'b1; bus_write = wr; bus_addr = 13'(addr);
        bus_strb = strb; bus_wdata = data;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_strb = '0; bus_wdata = '0;
        check(req, "rd_valid", 32'(rd_valid), 32'(exp_rv));
        if (exp_rv) check(req, "rd_data", rd_data, exp_rd);
        check(req, "upd_valid", 32'(upd_valid), 32'(exp_uv));
        if (exp_uv) begin
            check(req, "upd_idx", 32'(upd_idx), 32'(w));
            check(req, "upd_kind", 32'(upd_kind), 32'(k));
            check(req, "upd_unit", 32'(upd_unit), 32'(u));
            mem[w] = {8'h00, data[23:0]};
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check("R10", "idle rd_valid", 32'(rd_valid), 32'h0);
            check("R10", "idle upd_valid", 32'(upd_valid), 32'h0);
        end
    endtask

    task automatic put(int w, logic [31:0] v, string req);
        access(1, w * 4, 4'hF, {8'h5A, v[23:0]}, req);
    endtask

    task automatic get(int w, string req);
        access(0, w * 4, 4'hF, 32'h0, req);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset rd_valid", 32'(rd_valid), 32'h0);
        check("R1", "reset upd_valid", 32'(upd_valid), 32'h0);

        // R1: defaults of every stored word and the lock word
        get(2, "R1");
        for (int w = 0; w < 80; w++) begin
            int k, u;
            if (owner(w, k, u)) get(w, "R1");
        end

        // R2 / R6 / R7: walk every stored word with a distinct pattern
        for (int w = 0; w < 80; w++) begin
            int k, u;
            if (owner(w, k, u)) begin
                put(w, 32'h00A0_0000 ^ (w * 32'h0001_0203) ^ 32'h0000_0EFE,
                    (k == 3) ? "R7" : "R6");
                get(w, "R2");
            end
        end
        put(33, 32'hFFFFFFFF, "R2");
        get(33, "R2");
        put(33, 32'h00123456, "R2");
        access(1, 33 * 4, 4'hF, 32'h5A00_0001, "R2");
        get(33, "R2");

        // R5: lock assembly over analog reset and power-down combinations
        model_reset();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        get(2, "R5");
        put(4, 32'h0, "R5");          get(2, "R5");  // pll0 arst clear, pwrdn set
        put(16, 32'h0, "R5");         get(2, "R5");  // pll0 locked
        put(19, 32'h0, "R5");         get(2, "R5");  // pll3 pwrdn clear, arst set
        put(7, 32'h0000_00FF, "R5");  get(2, "R5");  // pll3 locked (bit 8 clear)
        put(17, 32'h00FE_FFFF, "R5"); put(5, 32'h00FF_FEFF, "R5"); get(2, "R5");
        put(4, 32'h0000_0100, "R5");  get(2, "R5");  // pll0 back in reset
        put(18, 32'h0, "R5"); put(6, 32'h0, "R5");   get(2, "R5");

        // R3: wrong keys
        access(1, 35 * 4, 4'hF, 32'hA5_001234, "R3"); get(35, "R3");
        access(1, 18 * 4, 4'hF, 32'h00_010000, "R3"); get(18, "R3");
        access(1, 66 * 4, 4'hF, 32'h5B_000777, "R3"); get(66, "R3");
        get(2, "R3");

        // R4: partial and misaligned accesses
        access(1, 66 * 4, 4'h3, 32'h5A_00ABCD, "R4"); get(66, "R4");
        access(1, 66 * 4 + 1, 4'hF, 32'h5A_00ABCD, "R4"); get(66, "R4");
        access(1, 6 * 4 + 2, 4'hF, 32'h5A_000100, "R4"); get(2, "R4");
        access(0, 67 * 4, 4'h7, 32'h0, "R4");
        access(0, 67 * 4 + 3, 4'hF, 32'h0, "R4");
        access(0, 2 * 4, 4'hE, 32'h0, "R4");

        // R7: control and divide of each mux
        for (int m = 0; m < 4; m++) begin
            put(64 + 2 * m, 32'h0000_0011 + m, "R7");
            put(65 + 2 * m, 32'h0000_2800 + m, "R7");
        end

        // R8: lock word and unmapped words
        access(1, 2 * 4, 4'hF, 32'h5A_FFFFFF, "R8"); get(2, "R8");
        put(100, 32'h00ABCDEF, "R8"); get(100, "R8");
        put(0, 32'h00000001, "R8");   get(0, "R8");
        put(40, 32'h00000001, "R8");  get(40, "R8");
        put(2047, 32'h00FFFFFF, "R8"); get(2047, "R8");
        put(72, 32'h00000003, "R8");  get(72, "R8");

        // R9: back-to-back reads
        get(37, "R9"); get(65, "R9"); get(2, "R9");

        idle(4);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog all-requirements actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule